// File: doc/BRIEF.md
# Single Cycle Reference Period Monitor

This block checks each cycle of up to several reference clocks. For each reference it counts master clock cycles from one rising edge to the next. It compares that count with a nominal period, given in master cycles. The nominal value can come from software or from a frequency detector. A period more than half the nominal value away from the nominal, on either side, marks the reference as failed. A reference that stops toggling is also marked failed, and this happens as soon as the running count passes one and a half nominal periods. The block does not wait for a late edge. The per-reference failure flags feed the qualification logic of a clock mode controller. Each reference also reports its most recent measured period.

The reference input is asynchronous to the master clock. Inside each channel it passes through a two-flop synchronizer and a rising-edge detector. A small state machine with four states drives the counter:

- IDLE: the channel is disabled or the nominal period is zero.
- ARM: the channel waits for a first edge.
- MEASURE: a period is being timed.
- LOST: the count has overrun and the channel waits for any edge.

The transitions are:

- IDLE to ARM when the channel is enabled with a nonzero nominal.
- ARM to MEASURE on an edge.
- MEASURE to MEASURE on each edge, which judges the period just timed.
- MEASURE to LOST on an overrun.
- LOST to MEASURE on an edge.
- Any state to IDLE when the channel is disabled or the nominal is zero.

A failure is sticky. It clears only after a programmable run of consecutive good periods.

Top module: `scpm_bank`

## Requirements
- R1: Each reference passes through a two-flop synchronizer and a rising-edge detector. A rising edge that the master clock samples at edge k is acted on by the channel at edge k+2.
- R2: A judged edge loads the number of master cycles since the previous rising edge into that channel's slice of `period_flat`.
- R3: The first edge after the channel becomes active starts a measurement only. It leaves `fail_o` and `period_flat` unchanged. The first edge after a missing-edge detection behaves the same way.
- R4: A measured period P with 2·P < N, where N is the nominal period, sets the channel's `fail_o`. P = N/2 is accepted.
- R5: A measured period P with 2·P > 3·N sets `fail_o`. P = 1.5·N is accepted.
- R6: If the running count exceeds 1.5·N with no edge, `fail_o` is set one cycle later, without waiting for an edge. `period_flat` is not changed.
- R7: Once set, `fail_o` stays high until `good_run` consecutive accepted periods have been judged. It falls on the judged edge of the last period in that run.
- R8: While `mon_en` is low or N is zero, `fail_o` is driven low one cycle later and the counter is held cleared. Edges are ignored and `period_flat` keeps its last value.
- R9: Each reference has its own channel with its own enable and nominal period. A failure on one channel does not affect another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_in | input | NUM_REFS | Reference clocks, asynchronous to clk |
| mon_en | input | NUM_REFS | Per-channel monitor enable |
| nominal_flat | input | NUM_REFS*CNT_W | Per-channel nominal period in master cycles; channel i uses bits [i*CNT_W +: CNT_W] |
| good_run | input | RUN_W | Number of consecutive good periods needed to clear a failure (0 acts as 1) |
| fail_o | output | NUM_REFS | Per-channel sticky failure flag |
| period_flat | output | NUM_REFS*CNT_W | Per-channel last judged period; channel i at bits [i*CNT_W +: CNT_W] |

## Verification
The bench changes the references only on falling clock edges. A rise placed there reaches the channel three rising edges later, so judged results are settled at the next falling edge. Each pulse train task waits at least that long after its last rise before it checks anything. The missing-edge flag is due 34 falling edges after the last rise when N = 20. The bench checks that the flag is still low one falling edge earlier and high exactly at that edge. Effects of the enable and of the nominal period are sampled one falling edge after the change.

// File: rtl/scpm_pkg.sv
package scpm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ARM     = 2'd1,
        ST_MEASURE = 2'd2,
        ST_LOST    = 2'd3
    } scpm_state_e;
endpackage

// File: rtl/scpm_edge_sync.sv
module scpm_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_o
);
    logic [SYNC_STAGES-1:0] chain_q;
    logic                   prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[SYNC_STAGES-2:0], async_in};
            prev_q  <= chain_q[SYNC_STAGES-1];
        end
    end

    assign rise_o = chain_q[SYNC_STAGES-1] & ~prev_q;

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o); // R1
endmodule

// File: rtl/scpm_window.sv
module scpm_window #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] count_i,
    input  logic [CNT_W-1:0] nominal_i,
    output logic             too_short_o,
    output logic             too_long_o
);
    localparam int EW = CNT_W + 2;

    logic [EW-1:0] twice_cnt;
    logic [EW-1:0] once_nom;
    logic [EW-1:0] thrice_nom;

    always_comb begin
        twice_cnt   = {1'b0, count_i, 1'b0};
        once_nom    = {2'b00, nominal_i};
        thrice_nom  = once_nom + {1'b0, nominal_i, 1'b0};
        too_short_o = twice_cnt < once_nom;
        too_long_o  = twice_cnt > thrice_nom;
    end
endmodule

// File: rtl/scpm_channel.sv
module scpm_channel
    import scpm_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int RUN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_i,
    input  logic             en_i,
    input  logic [CNT_W-1:0] nominal_i,
    input  logic [RUN_W-1:0] good_run_i,
    output logic             fail_o,
    output logic [CNT_W-1:0] period_o
);
    scpm_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_q;
    logic             fail_q;
    logic [RUN_W-1:0] good_q;
    logic [RUN_W:0]   good_next;
    logic [RUN_W:0]   run_eff;
    logic             rise;
    logic             active;
    logic             too_short;
    logic             too_long;

    scpm_edge_sync #(.SYNC_STAGES(2)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ref_i),
        .rise_o   (rise)
    );

    scpm_window #(.CNT_W(CNT_W)) u_win (
        .count_i     (cnt_q),
        .nominal_i   (nominal_i),
        .too_short_o (too_short),
        .too_long_o  (too_long)
    );

    assign active    = en_i && (nominal_i != '0);
    assign good_next = {1'b0, good_q} + 1'b1;
    // a run length of zero behaves as a run of one
    assign run_eff   = (good_run_i == '0) ? {{RUN_W{1'b0}}, 1'b1} : {1'b0, good_run_i};

    // next-state selection
    always_comb begin
        state_d = state_q;
        if (!active) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:    state_d = ST_ARM;
                ST_ARM:     if (rise) state_d = ST_MEASURE;
                ST_MEASURE: if (!rise && too_long) state_d = ST_LOST;
                ST_LOST:    if (rise) state_d = ST_MEASURE;
                default:    state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // counter, verdict and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            last_q <= '0;
            fail_q <= 1'b0;
            good_q <= '0;
        end else if (!active) begin
            cnt_q  <= '0;
            fail_q <= 1'b0;
            good_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    cnt_q  <= '0;
                    good_q <= '0;
                end
                ST_ARM, ST_LOST: begin
                    if (rise) cnt_q <= {{(CNT_W-1){1'b0}}, 1'b1};
                end
                ST_MEASURE: begin
                    if (rise) begin
                        cnt_q  <= {{(CNT_W-1){1'b0}}, 1'b1};
                        last_q <= cnt_q;
                        if (too_short || too_long) begin
                            fail_q <= 1'b1;
                            good_q <= '0;
                        end else if (good_next >= run_eff) begin
                            fail_q <= 1'b0;
                            good_q <= '0;
                        end else begin
                            good_q <= good_next[RUN_W-1:0];
                        end
                    end else if (too_long) begin
                        fail_q <= 1'b1;
                        good_q <= '0;
                    end else if (cnt_q != '1) begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: cnt_q <= '0;
            endcase
        end
    end

    assign fail_o   = fail_q;
    assign period_o = last_q;

    AST_IDLE_NO_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !fail_q); // R8
    AST_FAIL_FROM_MEASURE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail_q) |-> ($past(state_q) == ST_MEASURE)); // R6
    AST_CLEAR_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fail_q) |-> ($past(!active) || ($past(rise) && $past(state_q) == ST_MEASURE))); // R7
    AST_PERIOD_ON_JUDGE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(last_q) |-> ($past(rise) && $past(state_q) == ST_MEASURE)); // R3
endmodule

// File: rtl/scpm_bank.sv
module scpm_bank #(
    parameter int NUM_REFS = 3,
    parameter int CNT_W    = 16,
    parameter int RUN_W    = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_REFS-1:0]       ref_in,
    input  logic [NUM_REFS-1:0]       mon_en,
    input  logic [NUM_REFS*CNT_W-1:0] nominal_flat,
    input  logic [RUN_W-1:0]          good_run,
    output logic [NUM_REFS-1:0]       fail_o,
    output logic [NUM_REFS*CNT_W-1:0] period_flat
);
    for (genvar g = 0; g < NUM_REFS; g++) begin : g_chan
        scpm_channel #(.CNT_W(CNT_W), .RUN_W(RUN_W)) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .ref_i      (ref_in[g]),
            .en_i       (mon_en[g]),
            .nominal_i  (nominal_flat[g*CNT_W +: CNT_W]),
            .good_run_i (good_run),
            .fail_o     (fail_o[g]),
            .period_o   (period_flat[g*CNT_W +: CNT_W])
        );
    end
endmodule

// File: tb/tb_scpm_bank.sv
module tb_scpm_bank;
    localparam int NR = 3;
    localparam int CW = 16;
    localparam int RW = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NR-1:0]    ref_in = '0;
    logic [NR-1:0]    mon_en = '0;
    logic [NR*CW-1:0] nominal_flat = '0;
    logic [RW-1:0]    good_run = 4'd8;
    logic [NR-1:0]    fail_o;
    logic [NR*CW-1:0] period_flat;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    scpm_bank #(.NUM_REFS(NR), .CNT_W(CW), .RUN_W(RW)) dut (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .mon_en(mon_en),
        .nominal_flat(nominal_flat), .good_run(good_run),
        .fail_o(fail_o), .period_flat(period_flat)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int per(input int ch);
        return int'(period_flat[ch*CW +: CW]);
    endfunction

    task automatic train(input logic [NR-1:0] mask, input int p, input int n);
        for (int i = 0; i < n; i++) begin
            ref_in = ref_in | mask;
            repeat (p / 2) @(negedge clk);
            ref_in = ref_in & ~mask;
            repeat (p - p / 2) @(negedge clk);
        end
    endtask

    task automatic t_reset();
        chk("R8 reset fail", int'(fail_o), 0);
        chk("R2 reset period", per(0), 0);
    endtask

    task automatic t_disabled();
        nominal_flat[0*CW +: CW] = 16'd20;
        train(3'b001, 9, 3);
        chk("R8 disabled fail0", int'(fail_o[0]), 0);
        chk("R8 disabled period0", per(0), 0);
    endtask

    task automatic t_first_edge();
        mon_en[0] = 1'b1;
        @(negedge clk);
        train(3'b001, 20, 1);
        chk("R3 first edge period", per(0), 0);
        chk("R3 first edge fail", int'(fail_o[0]), 0);
        train(3'b001, 20, 4);
        chk("R2 nominal period", per(0), 20);
        chk("R1 nominal fail", int'(fail_o[0]), 0);
    endtask

    task automatic t_boundaries();
        train(3'b001, 10, 3);
        chk("R4 half period accepted", int'(fail_o[0]), 0);
        chk("R2 half period value", per(0), 10);
        train(3'b001, 30, 3);
        chk("R5 1.5x period accepted", int'(fail_o[0]), 0);
        chk("R2 1.5x period value", per(0), 30);
        train(3'b001, 9, 2);
        chk("R4 short period fails", int'(fail_o[0]), 1);
        chk("R2 short period value", per(0), 9);
    endtask

    task automatic t_sticky();
        train(3'b001, 20, 8);   // bad 9, then 7 good
        chk("R7 still failed after 7 good", int'(fail_o[0]), 1);
        train(3'b001, 20, 1);   // 8th good
        chk("R7 cleared after 8 good", int'(fail_o[0]), 0);
        train(3'b001, 31, 2);
        chk("R5 long period fails", int'(fail_o[0]), 1);
        chk("R2 long period value", per(0), 31);
        train(3'b001, 20, 9);   // 31 bad then 8 good
        chk("R7 cleared after long", int'(fail_o[0]), 0);
    endtask

    task automatic t_missing();
        repeat (13) @(negedge clk);
        chk("R6 no flag before overrun", int'(fail_o[0]), 0);
        @(negedge clk);
        chk("R6 missing edge flagged", int'(fail_o[0]), 1);
        chk("R6 period untouched", per(0), 20);
        train(3'b001, 20, 1);
        chk("R3 restart edge unjudged period", per(0), 20);
        chk("R3 restart edge keeps fail", int'(fail_o[0]), 1);
        train(3'b001, 20, 8);
        chk("R7 recovered after missing", int'(fail_o[0]), 0);
    endtask

    task automatic t_independent();
        mon_en[0] = 1'b0;
        nominal_flat[1*CW +: CW] = 16'd50;
        nominal_flat[2*CW +: CW] = 16'd20;
        mon_en[2:1] = 2'b11;
        @(negedge clk);
        chk("R8 disable clears fail0", int'(fail_o[0]), 0);
        train(3'b110, 20, 3);
        chk("R9 ch1 fails", int'(fail_o[1]), 1);
        chk("R9 ch2 good", int'(fail_o[2]), 0);
        chk("R9 ch1 period", per(1), 20);
        chk("R9 ch2 period", per(2), 20);
        chk("R8 ch0 period retained", per(0), 20);
    endtask

    task automatic t_nominal_zero();
        nominal_flat[1*CW +: CW] = 16'd0;
        @(negedge clk);
        chk("R8 zero nominal clears fail", int'(fail_o[1]), 0);
        train(3'b010, 9, 2);
        chk("R8 zero nominal ignores edges", int'(fail_o[1]), 0);
        chk("R8 zero nominal period kept", per(1), 20);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_disabled();
        t_first_edge();
        t_boundaries();
        t_sticky();
        t_missing();
        t_independent();
        t_nominal_zero();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule